// File: doc/BRIEF.md
# USB Full-Speed Transmit Serializer

This block turns a stream of bytes into the signalling of a USB full-speed line at 12 Mb/s. It runs from a single 48 MHz clock and spaces each line symbol four clocks apart. The bytes arrive through a valid/ready handshake of the kind UTMI defines for transmit. The link layer raises the valid input with the first byte. The serializer first sends the synchronisation pattern and then the bytes, least significant bit first. It inserts a stuff bit after every run of six ones and NRZI-codes the result. When valid falls, it closes the packet with an end-of-packet sequence.

Two output pins drive an external transceiver. A mode input selects one of two pin encodings, so the block can drive transceivers with either input convention. An active-high output enable marks the packet on the wire. The link layer generates the packet contents and CRC.

Top module: `usb_fs_tx_serializer`

## Requirements
- R1: While reset is high, and in the cycles after it before any packet, `tx_oe` is 0, `tx_ready` is 0 and the pins show idle J ({txdn,txdp} = 01). Whenever `tx_oe` is 0 the pins show J.
- R2: Every line symbol is held for exactly four clock cycles.
- R3: Each packet begins with the synchronisation bits 0,0,0,0,0,0,0,1 (byte value 0x80 sent LSB first). After NRZI starting from J, the line therefore shows K,J,K,J,K,J,K,K, and the first symbol with `tx_oe` high is K.
- R4: Data bytes follow in the order they were accepted, each sent LSB first. NRZI coding toggles the line between J and K for a 0 and holds it for a 1.
- R5: After six consecutive 1 bits, a 0 bit is inserted. The run counter spans the sync pattern and byte borders, and the inserted bit is NRZI-coded like any other. A stuff bit that falls due after the last data bit is still sent before the end of packet.
- R6: After the final bit the line shows SE0 for two symbols and J for one symbol. Then `tx_oe` returns to 0.
- R7: `tx_ready` is a single-cycle pulse, given once for each byte taken from `tx_data`, and only in a cycle after `tx_valid` was high. The number of pulses in a packet equals the number of data bytes. Dropping `tx_valid` after the last pulse ends the packet.
- R8: With `line_mode` = 0 the pins {txdn,txdp} are 01 for J, 00 for K and 10 for SE0.
- R9: With `line_mode` = 1 the pins are 01 for J, 10 for K and 00 for SE0. The pair 11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| line_mode | input | 1 | Pin encoding select (0 or 1, see R8/R9) |
| tx_data | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | Byte on tx_data is valid; low ends the packet |
| tx_ready | output | 1 | One-cycle pulse: tx_data has been taken |
| txdp | output | 1 | Transceiver drive pin, plus side |
| txdn | output | 1 | Transceiver drive pin, minus side |
| tx_oe | output | 1 | High while a packet is on the line |

## Verification
A corrupted bit counter or shift register shows up within one byte time as a wrong symbol somewhere after the sync pattern. A faulty stuff counter changes the symbol count of any packet that holds six ones in a row. The bench therefore compares whole packets symbol by symbol against a stream computed independently, checks the length and the end-of-packet sequence, and counts handshake pulses. A fault in the divider or in pin encoding is visible on the very first symbol of a packet, as a hold time other than four clocks or an unexpected pin pair.

// File: rtl/usb_fs_tx_pkg.sv
package usb_fs_tx_pkg;
  typedef enum logic [1:0] {
    SYM_K   = 2'd0,
    SYM_J   = 2'd1,
    SYM_SE0 = 2'd2
  } line_sym_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XMIT = 2'd1,
    ST_EOP  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/usb_fs_bit_clock_en.sv
module usb_fs_bit_clock_en #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/usb_fs_bit_engine.sv
module usb_fs_bit_engine
  import usb_fs_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output line_sym_t         sym,
  output logic              oe
);
  localparam int BW = $clog2(DATA_W + 1);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam logic [DATA_W-1:0] SYNC_WORD = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [BW-1:0] FULL = BW'(DATA_W);
  localparam logic [OW-1:0] RUN  = OW'(STUFF_RUN);

  eng_state_t        state;
  logic [DATA_W-1:0] sr;
  logic [BW-1:0]     bits_left;
  logic [OW-1:0]     ones;
  logic              lvl;
  logic [1:0]        eop_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sr        <= '0;
      bits_left <= '0;
      ones      <= '0;
      lvl       <= 1'b1;
      eop_cnt   <= 2'd0;
      sym       <= SYM_J;
      oe        <= 1'b0;
      tx_ready  <= 1'b0;
    end else begin
      tx_ready <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            sym <= SYM_J;
            oe  <= 1'b0;
            if (tx_valid) begin
              sr        <= SYNC_WORD;
              bits_left <= FULL;
              ones      <= '0;
              lvl       <= 1'b1;
              state     <= ST_XMIT;
            end
          end
          ST_XMIT: begin
            oe <= 1'b1;
            if (ones == RUN) begin
              // inserted zero: line toggles
              lvl  <= ~lvl;
              sym  <= lvl ? SYM_K : SYM_J;
              ones <= '0;
            end else if (bits_left != '0) begin
              if (sr[0]) begin
                sym  <= lvl ? SYM_J : SYM_K;
                ones <= ones + 1'b1;
              end else begin
                lvl  <= ~lvl;
                sym  <= lvl ? SYM_K : SYM_J;
                ones <= '0;
              end
              if (bits_left == BW'(1) && tx_valid) begin
                sr        <= tx_data;
                bits_left <= FULL;
                tx_ready  <= 1'b1;
              end else begin
                sr        <= {1'b0, sr[DATA_W-1:1]};
                bits_left <= bits_left - 1'b1;
              end
            end else begin
              sym     <= SYM_SE0;
              eop_cnt <= 2'd0;
              state   <= ST_EOP;
            end
          end
          ST_EOP: begin
            case (eop_cnt)
              2'd0: begin
                sym     <= SYM_SE0;
                eop_cnt <= 2'd1;
              end
              2'd1: begin
                sym     <= SYM_J;
                eop_cnt <= 2'd2;
              end
              default: begin
                sym   <= SYM_J;
                oe    <= 1'b0;
                lvl   <= 1'b1;
                state <= ST_IDLE;
              end
            endcase
          end
          default: begin
            state <= ST_IDLE;
            oe    <= 1'b0;
            sym   <= SYM_J;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/usb_fs_line_encoder.sv
module usb_fs_line_encoder
  import usb_fs_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      line_mode,
  input  line_sym_t sym,
  input  logic      oe_in,
  output logic      txdp,
  output logic      txdn,
  output logic      tx_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      txdp  <= 1'b1;
      txdn  <= 1'b0;
      tx_oe <= 1'b0;
    end else begin
      tx_oe <= oe_in;
      case (sym)
        SYM_K: begin
          txdp <= 1'b0;
          txdn <= line_mode;
        end
        SYM_SE0: begin
          txdp <= 1'b0;
          txdn <= ~line_mode;
        end
        default: begin
          txdp <= 1'b1;
          txdn <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/usb_fs_tx_serializer.sv
module usb_fs_tx_serializer
  import usb_fs_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CLK_DIV   = 4,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_mode,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txdp,
  output logic              txdn,
  output logic              tx_oe
);
  logic      bit_tick;
  line_sym_t eng_sym;
  logic      eng_oe;

  usb_fs_bit_clock_en #(.DIV(CLK_DIV)) clk_en_i (
    .clk  (clk),
    .rst  (rst),
    .tick (bit_tick)
  );

  usb_fs_bit_engine #(.DATA_W(DATA_W), .STUFF_RUN(STUFF_RUN)) engine_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (bit_tick),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .sym      (eng_sym),
    .oe       (eng_oe)
  );

  usb_fs_line_encoder enc_i (
    .clk       (clk),
    .rst       (rst),
    .line_mode (line_mode),
    .sym       (eng_sym),
    .oe_in     (eng_oe),
    .txdp      (txdp),
    .txdn      (txdn),
    .tx_oe     (tx_oe)
  );
endmodule

// File: rtl/usb_fs_tx_serializer_chk.sv
module usb_fs_tx_serializer_chk (
  input logic clk,
  input logic rst,
  input logic line_mode,
  input logic tx_valid,
  input logic tx_ready,
  input logic txdp,
  input logic txdn,
  input logic tx_oe
);
  p_ready_single_r7: assert property (@(posedge clk) disable iff (rst)
    tx_ready |=> !tx_ready);

  p_ready_after_valid_r7: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> $past(tx_valid));

  p_no_pair_11_r9: assert property (@(posedge clk) disable iff (rst)
    line_mode |-> !(txdp && txdn));

  p_idle_is_j_r1: assert property (@(posedge clk) disable iff (rst)
    !tx_oe |-> (txdp && !txdn));

  p_start_with_k_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_oe) |-> (!txdp && (txdn == line_mode)));
endmodule

bind usb_fs_tx_serializer usb_fs_tx_serializer_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .line_mode (line_mode),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .txdp      (txdp),
  .txdn      (txdn),
  .tx_oe     (tx_oe)
);

// File: tb/usb_fs_tx_serializer_tb_top.sv
`timescale 1ns/1ps
module usb_fs_tx_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_mode = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       txdp, txdn, tx_oe;

  always #2.5 clk = ~clk;

  usb_fs_tx_serializer dut_i (
    .clk(clk), .rst(rst), .line_mode(line_mode), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txdp(txdp), .txdn(txdn),
    .tx_oe(tx_oe)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  // symbol codes: 0 K, 1 J, 2 SE0, 3 illegal pair
  int pkt [0:299];
  int got [0:4095];
  int expv[0:4095];
  int nrec, nexp, hold_bad, pair_bad, phase;
  bit prev_oe = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int decode(input logic dn, input logic dp, input logic m);
    if ({dn, dp} == 2'b01) return 1;
    if (!m) begin
      if ({dn, dp} == 2'b00) return 0;
      if ({dn, dp} == 2'b10) return 2;
    end else begin
      if ({dn, dp} == 2'b10) return 0;
      if ({dn, dp} == 2'b00) return 2;
    end
    return 3;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // line monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_oe && !prev_oe) begin
        phase = 0; nrec = 0;
      end
      if (tx_oe) begin
        int s;
        s = decode(txdn, txdp, line_mode);
        if (s == 3) pair_bad++;
        if (phase == 1 && nrec < 4096) begin
          got[nrec] = s; nrec++;
        end
        if (phase == 3 && nrec > 0 && got[nrec-1] != s) hold_bad++;
        phase = (phase + 1) % 4;
      end
      if (!tx_oe && prev_oe) done = 1;
      prev_oe = tx_oe;
    end
  end

  task automatic build_expected(input int n);
    int bits[0:4095];
    int nb = 0;
    int ones = 0;
    int lvl = 1;
    for (int i = 0; i < 8 + 8 * n; i++) begin
      int b;
      if (i < 8) b = (i == 7) ? 1 : 0;
      else b = (pkt[(i - 8) / 8] >> ((i - 8) % 8)) & 1;
      bits[nb] = b; nb++;
      ones = b ? ones + 1 : 0;
      if (ones == 6) begin
        bits[nb] = 0; nb++; ones = 0;
      end
    end
    for (int i = 0; i < nb; i++) begin
      if (bits[i] == 0) lvl = 1 - lvl;
      expv[i] = lvl;
    end
    expv[nb] = 2; expv[nb+1] = 2; expv[nb+2] = 1;
    nexp = nb + 3;
  endtask

  task automatic run_packet(input int n, input bit m, input string name);
    int idx = 0;
    int rdy = 0;
    int mism = 0;
    int first_bad = -1;
    int t = 0;
    @(negedge clk);
    line_mode = m;
    hold_bad = 0; pair_bad = 0; done = 0;
    tx_data = pkt[0][7:0];
    tx_valid = 1'b1;
    while (!done && t < 40000) begin
      @(negedge clk);
      t++;
      if (tx_ready) begin
        rdy++; idx++;
        if (idx >= n) tx_valid = 1'b0;
        else tx_data = pkt[idx][7:0];
      end
    end
    tx_valid = 1'b0;
    build_expected(n);
    $display("[TB] packet %s mode=%0d bytes=%0d symbols=%0d", name, m, n, nrec);
    chk(done, "R6 packet end seen", done, 1);
    chk(nrec == nexp, "R5 symbol count with stuffing", nrec, nexp);
    for (int i = 0; i < 8; i++)
      if (got[i] != expv[i]) mism++;
    chk(mism == 0, "R3 sync symbols", mism, 0);
    mism = 0;
    for (int i = 0; i < nexp && i < nrec; i++)
      if (got[i] != expv[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    chk(mism == 0, "R4 symbol stream (first bad index in log)", first_bad, -1);
    chk(nrec >= 3 && got[nrec-3] == 2 && got[nrec-2] == 2 && got[nrec-1] == 1,
        "R6 SE0 SE0 J tail", nrec >= 3 ? got[nrec-1] : -1, 1);
    chk(rdy == n, "R7 ready pulses per packet", rdy, n);
    chk(hold_bad == 0, "R2 four-clock symbol hold", hold_bad, 0);
    if (m) chk(pair_bad == 0, "R9 mode 1 pin pairs", pair_bad, 0);
    else   chk(pair_bad == 0, "R8 mode 0 pin pairs", pair_bad, 0);
    repeat (6) @(negedge clk);
    chk(!tx_oe && txdp && !txdn, "R1 idle J after packet", {tx_oe, txdn, txdp}, 1);
  endtask

  task automatic load_kind(input int kind, output int n);
    case (kind)
      0: begin n = 1; pkt[0] = 8'h00; end
      1: begin n = 1; pkt[0] = 8'hFF; end
      2: begin n = 3; pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h3F; end
      3: begin n = 3; pkt[0] = 8'h7E; pkt[1] = 8'h01; pkt[2] = 8'hFC; end
      default: begin
        n = 256;
        for (int i = 0; i < 256; i++) pkt[i] = i;
      end
    endcase
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!tx_oe && !tx_ready && txdp && !txdn, "R1 state in reset",
        {tx_oe, tx_ready, txdn, txdp}, 1);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(!tx_oe && !tx_ready && txdp && !txdn, "R1 idle after reset",
        {tx_oe, tx_ready, txdn, txdp}, 1);
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 5; k++) begin
        load_kind(k, n);
        run_packet(n, m[0], $sformatf("kind%0d", k));
      end
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule